// File: doc/BRIEF.md
# Time-Base and Watchdog Interrupt Generator

This block turns a 32768 Hz tick, supplied as a clock enable in the main clock domain, into a periodic time-base signal and a watchdog time-out. A single ripple-free binary chain counts ticks. Its low eight bits act as a divide-by-256 prescaler and its upper bits as the time-base stages. A three-bit rate code picks which chain bit drives the time-base square wave. The watchdog counts whole periods of that same wave, so its time-out interval always scales with the chosen rate.

The serial command decoder delivers single-cycle strobes. These enable, disable and clear the timer; enable, disable and clear the watchdog; enable and disable the interrupt output; and load a new rate code. The only output is an active-low interrupt line, meant for an open-drain pad. While the interrupt is enabled, the line is pulled low when a latched watchdog time-out is present, or when the timer is enabled and the time-base wave is high. A hold input, driven when the system is disabled, keeps the chain and the watchdog counter at zero.

Top module: `tbase_wdog_irq`

## Requirements
- R1: After reset, the timer, watchdog and interrupt enables are all off, the rate code is 7, and irq_n is high.
- R2: The chain advances by one only in cycles where tick_en is high. When tick_en is low, the time-base wave and the watchdog progress do not change.
- R3: Rate code k (0 to 7), loaded with rate_stb, gives a 50 % duty square wave with a period of 2^(15-k) ticks, which is 2^k Hz. The wave is high during the second half of each period, counted from a chain value of zero.
- R4: With the interrupt enabled and no latched time-out, irq_n is the inverse of the time-base wave while the timer is enabled, and it stays high while the timer is disabled.
- R5: While the watchdog is enabled, it counts completed time-base periods. On the end of the 4th period after its last clear, it latches a time-out, and irq_n goes low whenever the interrupt is enabled.
- R6: A latched time-out stays until wdt_clr_stb or irq_dis_stb. wdt_clr_stb also restarts the period count from zero.
- R7: While the interrupt is disabled, irq_n is high. irq_dis_stb also discards a latched time-out, so a later irq_en_stb does not bring back the old time-out.
- R8: tmr_clr_stb sets the whole chain to zero. The wave then stays low for the next half period, and the strobe cycle does not count as a period end.
- R9: While sys_hold is high, the chain and the watchdog period count are held at zero. The enables and the rate code are kept.
- R10: The timer, watchdog and interrupt command groups act on their own state only. If the enable and disable strobes of one group arrive in the same cycle, the disable wins.
- R11: While the watchdog is disabled, its period count is frozen and no time-out can be latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz tick rate |
| sys_hold | input | 1 | Holds the chain and the watchdog count at zero |
| tmr_en_stb | input | 1 | Timer enable strobe |
| tmr_dis_stb | input | 1 | Timer disable strobe |
| tmr_clr_stb | input | 1 | Clears the shared chain |
| wdt_en_stb | input | 1 | Watchdog enable strobe |
| wdt_dis_stb | input | 1 | Watchdog disable strobe |
| wdt_clr_stb | input | 1 | Clears the watchdog count and its latched time-out |
| irq_en_stb | input | 1 | Interrupt enable strobe |
| irq_dis_stb | input | 1 | Interrupt disable strobe, also drops a latched time-out |
| rate_stb | input | 1 | Loads rate_code |
| rate_code | input | 3 | Rate code k, giving 2^k Hz |
| irq_n | output | 1 | Active-low interrupt for an open-drain pad |

## Verification
The bound checker watches several rules on every cycle. It checks that the chain is zero after a hold or a timer clear, and that the chain stays still when there is no tick. It checks that irq_n is high whenever the interrupt is disabled or was just disabled, and that a latched time-out survives until one of its two clearing strobes and pulls the line low. The exact cycle on which the wave edges fall for each rate code, the count of four periods before a time-out, freezing while disabled, and the disable-wins priority can only be seen by the bench's scenarios against its reference model.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  // Index of each command group inside the enable vector
  localparam int GRP_TMR = 0;
  localparam int GRP_WDT = 1;
  localparam int GRP_IRQ = 2;
  localparam int NGRP    = 3;

  typedef logic [NGRP-1:0] grp_vec_t;
endpackage

// File: rtl/tbw_divchain.sv
module tbw_divchain #(
  parameter int PRE_BITS = 8,
  parameter int RATES    = 8,
  localparam int CHAIN_W = PRE_BITS + RATES - 1,
  localparam int SEL_W   = $clog2(RATES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               hold,
  input  logic               clr,
  input  logic [SEL_W-1:0]   sel,
  output logic               wave,
  output logic               period_evt,
  output logic [CHAIN_W-1:0] chain_q
);
  localparam int TAP_W = $clog2(CHAIN_W);
  localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(CHAIN_W - 1);

  logic [CHAIN_W-1:0] chain_d;
  logic [TAP_W-1:0]   tap;
  logic               low_ones;

  // highest rate code selects the lowest time-base tap
  always_comb begin
    tap      = TOP_TAP - TAP_W'(sel);
    low_ones = 1'b1;
    for (int i = 0; i < CHAIN_W; i++) begin
      if (TAP_W'(i) <= tap) low_ones = low_ones & chain_q[i];
    end
    wave       = chain_q[tap];
    period_evt = tick_en & ~hold & ~clr & low_ones;
  end

  always_comb begin
    if (hold || clr)  chain_d = '0;
    else if (tick_en) chain_d = chain_q + 1'b1;
    else              chain_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/tbw_wdog.sv
module tbw_wdog #(
  parameter int PERIODS = 4,
  localparam int CW     = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic period_evt,
  input  logic en,
  input  logic clr,
  input  logic flag_clr,
  output logic flag_q
);
  localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_d;
  logic          step, expire;

  always_comb begin
    step   = period_evt & en;
    expire = step & (cnt_q == LAST);
    if (hold || clr)  cnt_d = '0;
    else if (expire)  cnt_d = '0;
    else if (step)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
    if (clr || flag_clr) flag_d = 1'b0;
    else if (expire)     flag_d = 1'b1;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  grp_vec_t         en_stb,
  input  grp_vec_t         dis_stb,
  input  logic             sel_stb,
  input  logic [SEL_W-1:0] sel_in,
  output grp_vec_t         en_q,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [SEL_W-1:0] SEL_RST = '1;

  grp_vec_t         en_d;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      if (dis_stb[g])     en_d[g] = 1'b0;
      else if (en_stb[g]) en_d[g] = 1'b1;
      else                en_d[g] = en_q[g];
    end
    sel_d = sel_stb ? sel_in : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= SEL_RST;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/tbase_wdog_irq.sv
module tbase_wdog_irq
  import tbw_pkg::*;
#(
  parameter int PRE_BITS    = 8,
  parameter int RATES       = 8,
  parameter int WDT_PERIODS = 4,
  localparam int SEL_W      = $clog2(RATES),
  localparam int CHAIN_W    = PRE_BITS + RATES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sys_hold,
  input  logic             tmr_en_stb,
  input  logic             tmr_dis_stb,
  input  logic             tmr_clr_stb,
  input  logic             wdt_en_stb,
  input  logic             wdt_dis_stb,
  input  logic             wdt_clr_stb,
  input  logic             irq_en_stb,
  input  logic             irq_dis_stb,
  input  logic             rate_stb,
  input  logic [SEL_W-1:0] rate_code,
  output logic             irq_n
);
  logic [1:0]         rst_sync_q;
  logic               rst_ns;
  grp_vec_t           en_stb, dis_stb, en_q;
  logic [SEL_W-1:0]   sel_q;
  logic               wave, period_evt, wdt_flag;
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  always_comb begin
    en_stb           = '0;
    dis_stb          = '0;
    en_stb[GRP_TMR]  = tmr_en_stb;
    en_stb[GRP_WDT]  = wdt_en_stb;
    en_stb[GRP_IRQ]  = irq_en_stb;
    dis_stb[GRP_TMR] = tmr_dis_stb;
    dis_stb[GRP_WDT] = wdt_dis_stb;
    dis_stb[GRP_IRQ] = irq_dis_stb;
  end

  tbw_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_ns), .en_stb(en_stb), .dis_stb(dis_stb),
    .sel_stb(rate_stb), .sel_in(rate_code), .en_q(en_q), .sel_q(sel_q)
  );

  tbw_divchain #(.PRE_BITS(PRE_BITS), .RATES(RATES)) chain_i (
    .clk(clk), .rst_n(rst_ns), .tick_en(tick_en), .hold(sys_hold),
    .clr(tmr_clr_stb), .sel(sel_q), .wave(wave), .period_evt(period_evt),
    .chain_q(chain_q)
  );

  tbw_wdog #(.PERIODS(WDT_PERIODS)) wdog_i (
    .clk(clk), .rst_n(rst_ns), .hold(sys_hold), .period_evt(period_evt),
    .en(en_q[GRP_WDT]), .clr(wdt_clr_stb), .flag_clr(irq_dis_stb),
    .flag_q(wdt_flag)
  );

  assign irq_n = ~(en_q[GRP_IRQ] & (wdt_flag | (en_q[GRP_TMR] & wave)));
endmodule

// File: rtl/tbw_chk.sv
module tbw_chk #(
  parameter int CHAIN_W = 15
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               tick_en,
  input logic               sys_hold,
  input logic               tmr_clr_stb,
  input logic               wdt_clr_stb,
  input logic               irq_dis_stb,
  input logic               irq_en,
  input logic               wdt_flag,
  input logic [CHAIN_W-1:0] chain_q,
  input logic               irq_n
);
  // R9
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sys_hold |=> (chain_q == '0));

  // R8
  tclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tmr_clr_stb |=> (chain_q == '0));

  // R2
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!tick_en && !sys_hold && !tmr_clr_stb) |=> $stable(chain_q));

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !irq_en |-> irq_n);

  // R7
  irq_dis_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_dis_stb |=> irq_n);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wdt_flag && !wdt_clr_stb && !irq_dis_stb) |=> wdt_flag);

  // R5
  flag_pull_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wdt_flag && irq_en) |-> !irq_n);
endmodule

bind tbase_wdog_irq tbw_chk #(.CHAIN_W(CHAIN_W)) chk_i (
  .clk(clk), .rst_ns(rst_ns), .tick_en(tick_en), .sys_hold(sys_hold),
  .tmr_clr_stb(tmr_clr_stb), .wdt_clr_stb(wdt_clr_stb),
  .irq_dis_stb(irq_dis_stb), .irq_en(en_q[tbw_pkg::GRP_IRQ]),
  .wdt_flag(wdt_flag), .chain_q(chain_q), .irq_n(irq_n)
);

// File: tb/tbase_wdog_irq_tb_top.sv
module tbase_wdog_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, sys_hold = 1'b0;
  logic tmr_en_stb = 1'b0, tmr_dis_stb = 1'b0, tmr_clr_stb = 1'b0;
  logic wdt_en_stb = 1'b0, wdt_dis_stb = 1'b0, wdt_clr_stb = 1'b0;
  logic irq_en_stb = 1'b0, irq_dis_stb = 1'b0, rate_stb = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic irq_n;

  int errors = 0, checks = 0, cyc = 0, tdiv = 1, ph = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_chain, m_wc, m_sel;
  bit m_flag, m_ten, m_wen, m_ien;

  always #10 clk = ~clk;

  tbase_wdog_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sys_hold(sys_hold),
    .tmr_en_stb(tmr_en_stb), .tmr_dis_stb(tmr_dis_stb), .tmr_clr_stb(tmr_clr_stb),
    .wdt_en_stb(wdt_en_stb), .wdt_dis_stb(wdt_dis_stb), .wdt_clr_stb(wdt_clr_stb),
    .irq_en_stb(irq_en_stb), .irq_dis_stb(irq_dis_stb), .rate_stb(rate_stb),
    .rate_code(rate_code), .irq_n(irq_n)
  );

  function automatic int tapbit(int k);
    return 14 - k;
  endfunction

  function automatic bit exp_irq_n();
    bit w;
    w = ((m_chain >> tapbit(m_sel)) & 1) != 0;
    return !(m_ien && (m_flag || (m_ten && w)));
  endfunction

  // behavioural model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain = 0; m_wc = 0; m_sel = 7;
      m_flag = 0; m_ten = 0; m_wen = 0; m_ien = 0;
    end else begin
      int per;
      bit evt;
      per = 1 << (tapbit(m_sel) + 1);
      evt = tick_en && !sys_hold && !tmr_clr_stb && ((m_chain % per) == per - 1);
      if (sys_hold || tmr_clr_stb) m_chain = 0;
      else if (tick_en) m_chain = (m_chain + 1) % 32768;
      if (wdt_clr_stb || irq_dis_stb) m_flag = 0;
      if (sys_hold || wdt_clr_stb) m_wc = 0;
      else if (evt && m_wen) begin
        m_wc = m_wc + 1;
        if (m_wc == 4) begin
          m_wc = 0;
          if (!irq_dis_stb) m_flag = 1;
        end
      end
      if (tmr_dis_stb) m_ten = 0; else if (tmr_en_stb) m_ten = 1;
      if (wdt_dis_stb) m_wen = 0; else if (wdt_en_stb) m_wen = 1;
      if (irq_dis_stb) m_ien = 0; else if (irq_en_stb) m_ien = 1;
      if (rate_stb) m_sel = int'(rate_code);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (chk_on && !done) begin
      checks++;
      if (irq_n !== exp_irq_n()) begin
        errors++;
        $display("FAIL %s cycle %0d: irq_n actual=%b expected=%b", cur_req, cyc, irq_n, exp_irq_n());
      end
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tmr_en_stb = 0; tmr_dis_stb = 0; tmr_clr_stb = 0;
      wdt_en_stb = 0; wdt_dis_stb = 0; wdt_clr_stb = 0;
      irq_en_stb = 0; irq_dis_stb = 0; rate_stb = 0;
      if (tdiv == 0) tick_en = 0;
      else begin
        tick_en = (ph == 0);
        ph = (ph + 1) % tdiv;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    tdiv = 0;
    cycles(3);
    rst_n = 1;
    cycles(4);
    chk_on = 1;
    // R1: idle state after reset
    cur_req = "R1";
    cycles(20);
    checks++;
    if (irq_n !== 1'b1) begin
      errors++; $display("FAIL R1: irq_n actual=%b expected=1", irq_n);
    end
    irq_en_stb = 1; cycles(300);
    // R4: timer gating, R3: rate 7
    cur_req = "R4"; tdiv = 1;
    tmr_en_stb = 1; cycles(600);
    cur_req = "R3";
    rate_code = 3'd6; rate_stb = 1; cycles(1100);
    rate_code = 3'd5; rate_stb = 1; cycles(2100);
    rate_code = 3'd7; rate_stb = 1; cycles(300);
    // R2: sparse ticks, then none
    cur_req = "R2"; tdiv = 3; cycles(900);
    tdiv = 0; cycles(200); tdiv = 1;
    // R8: clear mid period
    cur_req = "R8"; cycles(70);
    tmr_clr_stb = 1; cycles(400);
    // R5: watchdog timeout with timer output off
    cur_req = "R5";
    tmr_dis_stb = 1; cycles(1);
    wdt_clr_stb = 1; wdt_en_stb = 1; cycles(1150);
    cur_req = "R6"; cycles(300);
    wdt_clr_stb = 1; cycles(1100);
    // R7: irq disable drops the latch
    cur_req = "R7"; irq_dis_stb = 1; cycles(200);
    irq_en_stb = 1; cycles(100);
    // R11: frozen watchdog count
    cur_req = "R11"; wdt_dis_stb = 1; cycles(2000);
    wdt_en_stb = 1; cycles(1100);
    // R9: hold keeps counters at zero
    cur_req = "R9"; wdt_clr_stb = 1; cycles(500);
    sys_hold = 1; cycles(600);
    sys_hold = 0; cycles(1200);
    // R10: same-cycle enable and disable, group independence
    cur_req = "R10";
    tmr_en_stb = 1; tmr_dis_stb = 1; cycles(300);
    wdt_clr_stb = 1; tmr_en_stb = 1; cycles(400);
    tmr_dis_stb = 1; cycles(800);
    irq_en_stb = 1; irq_dis_stb = 1; cycles(200);
    wdt_en_stb = 1; wdt_dis_stb = 1; irq_en_stb = 1; cycles(1200);
    chk_on = 0;
    finish_run();
  end
endmodule